// File: doc/BRIEF.md
# Chip-Selected Synchronous Burst-Write Slave

This block is the slave end of a synchronous host bus that receives burst writes and stores each beat in a small internal write buffer. The host selects the slave with an active-low chip select and presents a 4-bit chip identifier. The slave reacts only to accesses whose identifier equals its configured value, and only to accesses shaped as burst writes. On the clock edge that claims an access, the slave latches the start address, the transfer type, the first data word and its byte enables.

The slave then paces the burst with an active-low acknowledge, one beat per asserted cycle. It withholds the acknowledge while the buffer is full, and the host keeps the current beat on the bus meanwhile. After the last beat the line is driven high for one cycle and then released. The release is modelled as a separate output enable. A downstream consumer empties the buffer through a valid/request drain port. A new access can follow with chip select held low throughout.

Top module: `burst_write_slave`

## Requirements
- R1: On the rising edge where `selN` is low and the access is claimed, `hostAddr`, `hostType`, `hostData` and `hostBe` are latched. Beat 0 in the buffer carries the latched data and byte enables, and every beat carries the latched type, whatever the bus shows later.
- R2: An access is claimed only when `hostChipId` equals `CHIP_ID`. With any other identifier, `ackOe` stays 0 and nothing enters the buffer.
- R3: A matching access is claimed only as a burst write: `hostBe` not all zero, `hostBurst` = 1 and `hostRdEn` = 0. Any other combination leaves `ackOe` at 0.
- R4: In each cycle with `ackOe` = 1 and `ackN` = 0, one beat is accepted. Beat k is stored with address (start + k) modulo 2^ADDR_W. From beat 1 on, the data and byte enables are the values on the bus in that cycle.
- R5: While the buffer is full, `ackN` is 1 with `ackOe` = 1, and the pending beat is not stored. The beat completes once space frees.
- R6: In the cycle after the final acknowledge, `ackOe` = 1 and `ackN` = 1. In the following cycle `ackOe` = 0, unless a new access was claimed.
- R7: With `selN` still low at the end of the release cycle, a new matching burst write is claimed at that edge and its beats follow at once.
- R8: A burst has 256/DATA_W beats: 4 beats for DATA_W = 64 and 8 beats for DATA_W = 32.
- R9: `drainValid` is 1 whenever the buffer holds a beat. The drain port shows the oldest entry, and `drainReq` with `drainValid` removes it at the edge. Entries leave in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| selN | input | 1 | Active-low chip select |
| hostAddr | input | ADDR_W | Burst start address (word units) |
| hostType | input | 2 | Transfer type code, stored with each beat |
| hostChipId | input | 4 | Target chip identifier |
| hostData | input | DATA_W | Write data |
| hostBe | input | DATA_W/8 | Byte-write enables, active high |
| hostRdEn | input | 1 | Read strobe, must be 0 for a write |
| hostBurst | input | 1 | Burst flag, must be 1 |
| ackN | output | 1 | Active-low transfer acknowledge (data) |
| ackOe | output | 1 | Acknowledge output enable; 0 means released |
| drainReq | input | 1 | Consumer removes the presented entry |
| drainValid | output | 1 | Buffer holds at least one entry |
| drainAddr | output | ADDR_W | Address of the presented entry |
| drainType | output | 2 | Type of the presented entry |
| drainData | output | DATA_W | Data of the presented entry |
| drainBe | output | DATA_W/8 | Byte enables of the presented entry |

## Verification
A wrong beat counter shows at the acknowledge pins within one burst: the release cycle arrives one beat early or late. A wrong address counter or a wrong beat-0 source shows as a mismatched entry on the drain port once the consumer reaches it. A wrong full flag shows either as an acknowledge during back-pressure, on the first cycle the buffer fills, or as an entry missing from the drained sequence. A stuck state shows as `ackOe` still driven one cycle after release, or as `ackOe` rising for a foreign identifier.

// File: rtl/bw_pkg.sv
package bw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_BURST   = 2'd1,
    ST_RELEASE = 2'd2
  } bwState_t;

  typedef struct packed {
    logic capture;
    logic push;
    logic firstBeat;
  } bwStrobe_t;
endpackage

// File: rtl/bw_fifo.sv
module bw_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popEn,
  output logic [WIDTH-1:0] popData,
  output logic             notEmpty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign full     = (count == CNT_W'(DEPTH));
  assign notEmpty = (count != '0);
  assign doPush   = pushEn && !full;
  assign doPop    = popEn && notEmpty;
  assign popData  = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/bw_ctrl.sv
module bw_ctrl
  import bw_pkg::*;
#(
  parameter int         BEATS   = 4,
  parameter int         BE_W    = 8,
  parameter logic [3:0] CHIP_ID = 4'h5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            selN,
  input  logic [3:0]      hostChipId,
  input  logic [BE_W-1:0] hostBe,
  input  logic            hostRdEn,
  input  logic            hostBurst,
  input  logic            fifoFull,
  output bwStrobe_t       strobe,
  output logic            ackN,
  output logic            ackOe
);
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  bwState_t          state, stateNext;
  logic [BEAT_W-1:0] beatCnt;
  logic              accessOk, beatGo, lastBeat;

  assign accessOk = !selN && (hostChipId == CHIP_ID) && (|hostBe) && hostBurst && !hostRdEn;
  assign beatGo   = (state == ST_BURST) && !fifoFull;
  assign lastBeat = beatGo && (beatCnt == BEAT_W'(BEATS - 1));

  assign strobe.capture   = (state != ST_BURST) && accessOk;
  assign strobe.push      = beatGo;
  assign strobe.firstBeat = (beatCnt == '0);

  assign ackN  = !beatGo;
  assign ackOe = (state != ST_IDLE);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:    if (accessOk) stateNext = ST_BURST;
      ST_BURST:   if (lastBeat) stateNext = ST_RELEASE;
      ST_RELEASE: stateNext = accessOk ? ST_BURST : ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobe.capture)   beatCnt <= '0;
      else if (beatGo)      beatCnt <= lastBeat ? '0 : beatCnt + 1'b1;
    end
  end
endmodule

// File: rtl/bw_datapath.sv
module bw_datapath
  import bw_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 64,
  parameter int BE_W   = 8,
  parameter int TYPE_W = 2,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  bwStrobe_t         strobe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [TYPE_W-1:0] hostType,
  input  logic [DATA_W-1:0] hostData,
  input  logic [BE_W-1:0]   hostBe,
  input  logic              drainReq,
  output logic              drainValid,
  output logic [ADDR_W-1:0] drainAddr,
  output logic [TYPE_W-1:0] drainType,
  output logic [DATA_W-1:0] drainData,
  output logic [BE_W-1:0]   drainBe,
  output logic              fifoFull
);
  localparam int ENTRY_W = ADDR_W + TYPE_W + DATA_W + BE_W;

  logic [ADDR_W-1:0]  curAddr;
  logic [TYPE_W-1:0]  capType;
  logic [DATA_W-1:0]  capData, beatData;
  logic [BE_W-1:0]    capBe, beatBe;
  logic [ENTRY_W-1:0] pushEntry, headEntry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      capType <= '0;
      capData <= '0;
      capBe   <= '0;
    end else if (strobe.capture) begin
      curAddr <= hostAddr;
      capType <= hostType;
      capData <= hostData;
      capBe   <= hostBe;
    end else if (strobe.push) begin
      curAddr <= curAddr + 1'b1;
    end
  end

  assign beatData  = strobe.firstBeat ? capData : hostData;
  assign beatBe    = strobe.firstBeat ? capBe   : hostBe;
  assign pushEntry = {curAddr, capType, beatData, beatBe};

  bw_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) beatBuf (
    .clk      (clk),
    .rstN     (rstN),
    .pushEn   (strobe.push),
    .pushData (pushEntry),
    .popEn    (drainReq),
    .popData  (headEntry),
    .notEmpty (drainValid),
    .full     (fifoFull)
  );

  assign {drainAddr, drainType, drainData, drainBe} = headEntry;
endmodule

// File: rtl/burst_write_slave.sv
module burst_write_slave
  import bw_pkg::*;
#(
  parameter int         ADDR_W     = 19,
  parameter int         DATA_W     = 64,
  parameter int         FIFO_DEPTH = 4,
  parameter logic [3:0] CHIP_ID    = 4'h5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  selN,
  input  logic [ADDR_W-1:0]     hostAddr,
  input  logic [1:0]            hostType,
  input  logic [3:0]            hostChipId,
  input  logic [DATA_W-1:0]     hostData,
  input  logic [DATA_W/8-1:0]   hostBe,
  input  logic                  hostRdEn,
  input  logic                  hostBurst,
  output logic                  ackN,
  output logic                  ackOe,
  input  logic                  drainReq,
  output logic                  drainValid,
  output logic [ADDR_W-1:0]     drainAddr,
  output logic [1:0]            drainType,
  output logic [DATA_W-1:0]     drainData,
  output logic [DATA_W/8-1:0]   drainBe
);
  localparam int BE_W  = DATA_W / 8;
  localparam int BEATS = 256 / DATA_W;

  bwStrobe_t strobe;
  logic      fifoFull;

  bw_ctrl #(.BEATS(BEATS), .BE_W(BE_W), .CHIP_ID(CHIP_ID)) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .selN       (selN),
    .hostChipId (hostChipId),
    .hostBe     (hostBe),
    .hostRdEn   (hostRdEn),
    .hostBurst  (hostBurst),
    .fifoFull   (fifoFull),
    .strobe     (strobe),
    .ackN       (ackN),
    .ackOe      (ackOe)
  );

  bw_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BE_W   (BE_W),
    .TYPE_W (2),
    .DEPTH  (FIFO_DEPTH)
  ) dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hostAddr   (hostAddr),
    .hostType   (hostType),
    .hostData   (hostData),
    .hostBe     (hostBe),
    .drainReq   (drainReq),
    .drainValid (drainValid),
    .drainAddr  (drainAddr),
    .drainType  (drainType),
    .drainData  (drainData),
    .drainBe    (drainBe),
    .fifoFull   (fifoFull)
  );
endmodule

// File: rtl/burst_write_slave_chk.sv
module burst_write_slave_chk #(
  parameter logic [3:0] CHIP_ID = 4'h5
) (
  input logic       clk,
  input logic       rstN,
  input logic       selN,
  input logic [3:0] hostChipId,
  input logic       ackN,
  input logic       ackOe,
  input logic       drainValid,
  input logic       fifoFull
);
  // R2: the line is only ever driven after a select carrying our identifier
  p_claim_needs_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOe) |-> $past(!selN && (hostChipId == CHIP_ID)));

  // R5: no beat acknowledged while the buffer is full
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !(ackOe && !ackN));

  // R6: the line is driven high before it is released
  p_release_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackOe) |-> $past(ackN));

  // R4: an acknowledged beat lands in the buffer
  p_ack_fills_buffer_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ackOe && !ackN) |=> drainValid);
endmodule

bind burst_write_slave burst_write_slave_chk #(.CHIP_ID(CHIP_ID)) chk (
  .clk        (clk),
  .rstN       (rstN),
  .selN       (selN),
  .hostChipId (hostChipId),
  .ackN       (ackN),
  .ackOe      (ackOe),
  .drainValid (drainValid),
  .fifoFull   (fifoFull)
);

// File: tb/burst_write_slave_test.sv
module burst_write_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 19;
  localparam int DATA_W = 64;
  localparam int BE_W = DATA_W / 8;
  localparam int BEATS = 256 / DATA_W;
  localparam logic [3:0] MY_ID = 4'h5;
  localparam int ENT_W = ADDR_W + 2 + DATA_W + BE_W;

  logic clk = 0;
  logic rstN = 0;
  logic selN = 1;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic [1:0] hostType = '0;
  logic [3:0] hostChipId = '0;
  logic [DATA_W-1:0] hostData = '0;
  logic [BE_W-1:0] hostBe = '0;
  logic hostRdEn = 0;
  logic hostBurst = 0;
  logic ackN, ackOe;
  logic drainReq = 0;
  logic drainValid;
  logic [ADDR_W-1:0] drainAddr;
  logic [1:0] drainType;
  logic [DATA_W-1:0] drainData;
  logic [BE_W-1:0] drainBe;

  int checks = 0;
  int fails = 0;
  bit drainEnable = 0;
  bit done = 0;
  logic [ENT_W-1:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_write_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIFO_DEPTH(4), .CHIP_ID(MY_ID)) uut (
    .clk(clk), .rstN(rstN), .selN(selN), .hostAddr(hostAddr), .hostType(hostType),
    .hostChipId(hostChipId), .hostData(hostData), .hostBe(hostBe), .hostRdEn(hostRdEn),
    .hostBurst(hostBurst), .ackN(ackN), .ackOe(ackOe), .drainReq(drainReq),
    .drainValid(drainValid), .drainAddr(drainAddr), .drainType(drainType),
    .drainData(drainData), .drainBe(drainBe));

  function automatic logic [DATA_W-1:0] beatData(input logic [ADDR_W-1:0] base, input int k);
    return {32'(32'(base) * 7 + k), 32'hC0DE0000 | 32'(k)};
  endfunction

  function automatic logic [BE_W-1:0] beatBe(input int k);
    return BE_W'(8'h11 << k) | BE_W'(1);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // consumer: compare each presented entry against the model queue (R9, R1, R4)
  initial begin
    forever begin
      @(negedge clk);
      if (drainEnable && drainValid) begin
        if (expQ.size() == 0) begin
          check(0, "R9", "unexpected entry", {drainAddr, drainType, drainData, drainBe}, 0);
        end else begin
          check({drainAddr, drainType, drainData, drainBe} == expQ[0], "R9/R4/R1",
                "drained entry", {drainAddr, drainType, drainData, drainBe}, expQ[0]);
          void'(expQ.pop_front());
        end
        drainReq = 1;
      end else begin
        drainReq = 0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(0, "WDOG", "run hung", 0, 1);
      summary();
    end
  end

  task automatic runBurst(input logic [ADDR_W-1:0] base, input logic [3:0] id,
                          input logic rd, input logic bst, input logic [BE_W-1:0] be0,
                          input logic [1:0] typ, input bit expectClaim, output int stalls);
    int beat;
    stalls = 0;
    selN = 0; hostAddr = base; hostChipId = id; hostType = typ;
    hostData = beatData(base, 0); hostBe = be0; hostRdEn = rd; hostBurst = bst;
    @(negedge clk);
    if (!expectClaim) begin
      check(ackOe == 0, "R2/R3", "unclaimed access drives line", ackOe, 0);
      @(negedge clk);
      check(ackOe == 0 && ackN == 1, "R2/R3", "unclaimed access held", {ackOe, ackN}, 2'b01);
      return;
    end
    beat = 0;
    while (beat < BEATS) begin
      hostAddr = ~base;
      hostType = ~typ;
      hostData = (beat == 0) ? 64'hBAD0BAD0BAD0BAD0 : beatData(base, beat);
      hostBe   = (beat == 0) ? '0 : beatBe(beat);
      check(ackOe == 1, "R4", "line driven during burst", ackOe, 1);
      if (ackN == 0) begin
        expQ.push_back({ADDR_W'(base + ADDR_W'(beat)), typ, beatData(base, beat),
                        (beat == 0) ? be0 : beatBe(beat)});
        beat++;
      end else begin
        stalls++;
        if (stalls > 60) begin
          check(0, "R5", "stall never ends", stalls, 0);
          return;
        end
      end
      @(negedge clk);
    end
    // release cycle right after beat BEATS-1 (R6, R8)
    check(ackOe == 1 && ackN == 1, "R6/R8", "release cycle after last beat", {ackOe, ackN}, 2'b11);
  endtask

  task automatic deselect();
    selN = 1; hostBe = '0; hostBurst = 0;
    @(negedge clk);
    check(ackOe == 0 && ackN == 1, "R6", "line released", {ackOe, ackN}, 2'b01);
  endtask

  initial begin
    int st;
    int waitCnt;
    repeat (3) @(negedge clk);
    check(ackOe == 0, "R6", "reset: line released", ackOe, 0);
    check(drainValid == 0, "R9", "reset: buffer empty", drainValid, 0);
    rstN = 1;
    @(negedge clk);
    drainEnable = 1;

    // R2: sweep every foreign identifier
    for (int id = 0; id < 16; id++) begin
      if (4'(id) != MY_ID) begin
        runBurst(19'h00040, 4'(id), 0, 1, beatBe(0), 2'd1, 0, st);
        deselect();
      end
    end
    check(drainValid == 0, "R2", "foreign ids buffered nothing", drainValid, 0);

    // R3: matching id, not a burst write
    runBurst(19'h00050, MY_ID, 1, 1, beatBe(0), 2'd1, 0, st); deselect();
    runBurst(19'h00050, MY_ID, 0, 0, beatBe(0), 2'd1, 0, st); deselect();
    runBurst(19'h00050, MY_ID, 0, 1, '0, 2'd1, 0, st); deselect();
    check(drainValid == 0, "R3", "non-burst-writes buffered nothing", drainValid, 0);

    // R1, R4, R6, R8: single burst
    runBurst(19'h00100, MY_ID, 0, 1, 8'hA5, 2'd2, 1, st);
    deselect();

    // R4: address wrap at the top of the range
    runBurst(19'h7FFFE, MY_ID, 0, 1, 8'h3C, 2'd3, 1, st);
    deselect();

    // R7: back-to-back without deselect
    runBurst(19'h00200, MY_ID, 0, 1, 8'h0F, 2'd0, 1, st);
    runBurst(19'h00300, MY_ID, 0, 1, 8'hF0, 2'd1, 1, st);
    check(st == 0, "R7", "back-to-back burst without stall", st, 0);
    deselect();

    // wait for the buffer to empty
    waitCnt = 0;
    while ((expQ.size() != 0 || drainValid) && waitCnt < 50) begin
      @(negedge clk); waitCnt++;
    end

    // R5: fill the buffer with drain off, then a back-to-back burst must stall
    drainEnable = 0;
    @(negedge clk);
    runBurst(19'h00400, MY_ID, 0, 1, 8'h55, 2'd2, 1, st);
    check(st == 0, "R5", "burst into empty buffer without stall", st, 0);
    fork
      begin
        runBurst(19'h00500, MY_ID, 0, 1, 8'hAA, 2'd3, 1, st);
      end
      begin
        repeat (6) @(negedge clk);
        drainEnable = 1;
      end
    join
    check(st >= 3, "R5", "acknowledge withheld while full", st, 3);
    deselect();

    waitCnt = 0;
    while ((expQ.size() != 0 || drainValid) && waitCnt < 50) begin
      @(negedge clk); waitCnt++;
    end
    check(expQ.size() == 0, "R9", "every accepted beat drained", expQ.size(), 0);
    check(drainValid == 0, "R9", "buffer empty at end", drainValid, 0);

    done = 1;
    summary();
  end
endmodule